// File: doc/BRIEF.md
# Vertical Transfer Pulse Pattern Generator

This block drives a group of vertical CCD transfer lines from a programmed pulse pattern. Every output has its own start level and six toggle slots. A burst begins at a programmed pixel of the horizontal line, provided the region input is high. The pattern is then played a programmed number of times back to back. A one-cycle done flag marks the final position of the burst.

Two options change how the pattern is laid out in time. Multiplier mode stretches it: each toggle slot counts in units of the length register instead of single pixels, so one pass can span many lines. Scan mode keeps a burst alive across line strobes until the burst finishes or the region ends. Without scan mode, the line strobe cuts the burst short, and the burst plays again in the next line.

Top module: `vxfer_pattern_gen`

## Requirements
- R1: After reset, every bit of `vout_o` is 0 and `done_o` is 0.
- R2: The line pixel count is 0 in the cycle after a cycle with `hd_i` high, and it then rises by one per clock. A burst starts in a cycle where `region_act_i` is high, `hd_i` is low, no burst is running, the count equals `vstart_i`, and no burst has yet started in this line (normal) or in this region (scan mode). Position p of the burst appears on `vout_o` p+1 clocks after that cycle.
- R3: In normal mode a burst lasts `vlen_i`×`vrep_i` positions. At position p, output i shows its start level `start_pol_i[i]` XOR the parity of how many of its used toggle values are ≤ p mod `vlen_i`. Each repetition therefore restarts from the start level.
- R4: Toggle k of output i is `tog_pos_i[(i*NUM_TOG+k)*POS_W +: POS_W]`. A value of all ones marks the slot as unused.
- R5: When multiplier mode is in effect, the comparison index is p div `vlen_i` instead of p mod `vlen_i`. A toggle value t thus switches at pixel t×`vlen_i`, and the single pass lasts `vrep_i`×`vlen_i` positions.
- R6: Multiplier mode is in effect only while `mult_en_i` is high and every bit of `grp_b_i` is 0. With any bit set, the block behaves as in normal mode.
- R7: Without scan mode, `hd_i` high during a burst ends the burst, and the outputs keep their level. The burst starts afresh in the next line at `vstart_i`.
- R8: In scan mode, `hd_i` does not end a burst, and only one burst runs per region. A low `region_act_i` ends any burst, and the outputs keep their level.
- R9: `done_o` is high for exactly one clock, in the clock in which the final burst position is shown. A burst that is cut short produces no `done_o`.
- R10: Outside a burst the outputs keep their last level.
- R11: A `vlen_i` or `vrep_i` of 0 is treated as 1.
- R12: While `region_act_i` is low, no burst starts and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line strobe, one clock wide |
| region_act_i | input | 1 | High while the vertical region is active |
| scan_en_i | input | 1 | Scan mode: line strobes do not end a burst |
| mult_en_i | input | 1 | Multiplier mode request |
| grp_b_i | input | NUM_OUT | Per output: assigned to the second group |
| start_pol_i | input | NUM_OUT | Start level of each output |
| tog_pos_i | input | NUM_OUT*NUM_TOG*POS_W | Toggle values, packed as in R4 |
| vstart_i | input | POS_W | Line pixel at which a burst starts |
| vlen_i | input | POS_W | Pattern length, or multiplier factor |
| vrep_i | input | POS_W | Repetition count, or pass length in units |
| vout_o | output | NUM_OUT | Vertical transfer pulse outputs |
| done_o | output | 1 | One-clock flag on the final burst position |

## Verification
The assertions take for granted that the configuration inputs do not change while a burst is running. They also assume that `hd_i` is a single-clock strobe. The bench respects this in two ways. It changes the length, repetition, start and mode settings only after `region_act_i` has been low for several clocks. It raises the line strobe for exactly one clock at each line start. Expected output levels come from the bench's own position arithmetic, which it works out from its line-strobe schedule.

// File: rtl/vxp_pkg.sv
package vxp_pkg;

    typedef struct packed {
        logic running;
        logic used;
        logic done;
    } vxp_flags_t;

endpackage

// File: rtl/vxp_line_counter.sv
module vxp_line_counter #(
    parameter int POS_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hd_i,
    output logic [POS_W-1:0] pix_o
);
    localparam logic [POS_W-1:0] PIX_MAX = '1;
    localparam logic [POS_W-1:0] PIX_ONE = POS_W'(1);

    logic [POS_W-1:0] pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (hd_i) begin
            pix_d = '0;
        end else if (pix_q != PIX_MAX) begin
            pix_d = pix_q + PIX_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pix_q <= '0;
        else         pix_q <= pix_d;
    end

    assign pix_o = pix_q;

endmodule

// File: rtl/vxp_burst_ctrl.sv
module vxp_burst_ctrl
    import vxp_pkg::*;
#(
    parameter int POS_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hd_i,
    input  logic             region_i,
    input  logic             scan_i,
    input  logic             mult_i,
    input  logic [POS_W-1:0] vstart_i,
    input  logic [POS_W-1:0] vlen_i,
    input  logic [POS_W-1:0] vrep_i,
    input  logic [POS_W-1:0] pix_i,
    output logic             load_o,
    output logic [POS_W-1:0] idx_o,
    output logic             done_o
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    typedef struct packed {
        vxp_flags_t       flags;
        logic [POS_W-1:0] sub;
        logic [POS_W-1:0] unit;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [POS_W-1:0] len_eff, rep_eff, cur_sub, cur_unit;
    logic             line_break, start, keep, active, sub_end, last;

    always_comb begin
        len_eff    = (vlen_i == '0) ? ONE : vlen_i;
        rep_eff    = (vrep_i == '0) ? ONE : vrep_i;
        line_break = hd_i & ~scan_i;
        start      = region_i & ~hd_i & ~st_q.flags.running
                     & ~st_q.flags.used & (pix_i == vstart_i);
        keep       = st_q.flags.running & region_i & ~line_break;
        active     = start | keep;
        cur_sub    = start ? '0 : st_q.sub;
        cur_unit   = start ? '0 : st_q.unit;
        sub_end    = (cur_sub == (len_eff - ONE));
        last       = active & sub_end & (cur_unit == (rep_eff - ONE));

        st_d            = st_q;
        st_d.flags.done = last;
        if (active) begin
            if (sub_end) begin
                st_d.sub  = '0;
                st_d.unit = cur_unit + ONE;
            end else begin
                st_d.sub  = cur_sub + ONE;
                st_d.unit = cur_unit;
            end
        end
        st_d.flags.running = active & ~last;
        if (start) begin
            st_d.flags.used = 1'b1;
        end else if (~region_i | line_break) begin
            st_d.flags.used = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign load_o = active;
    assign idx_o  = mult_i ? cur_unit : cur_sub;
    assign done_o = st_q.flags.done;

    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.flags.done |=> !st_q.flags.done);

    assert_done_ends_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.flags.done |-> !st_q.flags.running);

    assert_sub_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.flags.running |-> (st_q.sub < len_eff));

    assert_line_cut_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flags.running && hd_i && !scan_i) |=> !st_q.flags.running);

    assert_scan_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flags.running && scan_i && region_i) |=> (st_q.flags.running || st_q.flags.done));

    assert_idle_region_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !region_i |=> (!st_q.flags.running && !st_q.flags.done));

endmodule

// File: rtl/vxp_out_lane.sv
module vxp_out_lane #(
    parameter int POS_W   = 13,
    parameter int NUM_TOG = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [POS_W-1:0]         idx_i,
    input  logic                     pol_i,
    input  logic [NUM_TOG*POS_W-1:0] tog_i,
    output logic                     out_o
);
    localparam logic [POS_W-1:0] UNUSED = '1;

    logic lvl, out_d, out_q;

    always_comb begin
        lvl = pol_i;
        for (int k = 0; k < NUM_TOG; k++) begin
            if ((tog_i[k*POS_W +: POS_W] != UNUSED) && (tog_i[k*POS_W +: POS_W] <= idx_i)) begin
                lvl = ~lvl;
            end
        end
        out_d = load_i ? lvl : out_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= 1'b0;
        else         out_q <= out_d;
    end

    assign out_o = out_q;

endmodule

// File: rtl/vxfer_pattern_gen.sv
module vxfer_pattern_gen #(
    parameter int NUM_OUT = 4,
    parameter int NUM_TOG = 6,
    parameter int POS_W   = 13
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             hd_i,
    input  logic                             region_act_i,
    input  logic                             scan_en_i,
    input  logic                             mult_en_i,
    input  logic [NUM_OUT-1:0]               grp_b_i,
    input  logic [NUM_OUT-1:0]               start_pol_i,
    input  logic [NUM_OUT*NUM_TOG*POS_W-1:0] tog_pos_i,
    input  logic [POS_W-1:0]                 vstart_i,
    input  logic [POS_W-1:0]                 vlen_i,
    input  logic [POS_W-1:0]                 vrep_i,
    output logic [NUM_OUT-1:0]               vout_o,
    output logic                             done_o
);
    localparam int LANE_W = NUM_TOG * POS_W;

    logic [POS_W-1:0] pix;
    logic [POS_W-1:0] idx;
    logic             load;
    logic             mult_eff;

    assign mult_eff = mult_en_i & ~(|grp_b_i);

    vxp_line_counter #(.POS_W(POS_W)) u_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hd_i   (hd_i),
        .pix_o  (pix)
    );

    vxp_burst_ctrl #(.POS_W(POS_W)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hd_i     (hd_i),
        .region_i (region_act_i),
        .scan_i   (scan_en_i),
        .mult_i   (mult_eff),
        .vstart_i (vstart_i),
        .vlen_i   (vlen_i),
        .vrep_i   (vrep_i),
        .pix_i    (pix),
        .load_o   (load),
        .idx_o    (idx),
        .done_o   (done_o)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        vxp_out_lane #(.POS_W(POS_W), .NUM_TOG(NUM_TOG)) u_lane (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (load),
            .idx_i  (idx),
            .pol_i  (start_pol_i[i]),
            .tog_i  (tog_pos_i[i*LANE_W +: LANE_W]),
            .out_o  (vout_o[i])
        );
    end

    assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !region_act_i |=> $stable(vout_o));

endmodule

// File: tb/vxfer_pattern_gen_bench.sv
module vxfer_pattern_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 4;
    localparam int NT = 6;
    localparam int PW = 13;
    localparam int ALL1 = 8191;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd = 1'b0, region = 1'b0, scan = 1'b0, mult = 1'b0;
    logic [NO-1:0] grpb = '0, pol = '0;
    logic [NO*NT*PW-1:0] togs = '0;
    logic [PW-1:0] vstart = '0, vlen = '0, vrep = '0;
    logic [NO-1:0] vout;
    logic done;

    int checks = 0;
    int failures = 0;
    int tog_tb [NO][NT];
    logic [NO-1:0] exp_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vxfer_pattern_gen #(.NUM_OUT(NO), .NUM_TOG(NT), .POS_W(PW)) u_vxfer_pattern_gen (
        .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .region_act_i(region),
        .scan_en_i(scan), .mult_en_i(mult), .grp_b_i(grpb), .start_pol_i(pol),
        .tog_pos_i(togs), .vstart_i(vstart), .vlen_i(vlen), .vrep_i(vrep),
        .vout_o(vout), .done_o(done)
    );

    task automatic check(input string req, input logic [NO-1:0] act_o, input logic [NO-1:0] exp_o,
                         input logic act_d, input logic exp_d);
        checks++;
        if (act_o !== exp_o || act_d !== exp_d) begin
            failures++;
            $display("FAIL %s: vout=%b done=%b expected vout=%b done=%b", req, act_o, act_d, exp_o, exp_d);
        end
    endtask

    task automatic gen_tog(input int seed, input int range);
        for (int i = 0; i < NO; i++) begin
            pol[i] = logic'((seed + i) % 2);
            for (int k = 0; k < NT; k++) begin
                if ((seed + i + 2*k) % 5 == 4) tog_tb[i][k] = ALL1;
                else tog_tb[i][k] = (seed*3 + i*7 + k*5) % range;
            end
        end
    endtask

    task automatic pack_tog();
        for (int i = 0; i < NO; i++)
            for (int k = 0; k < NT; k++)
                togs[(i*NT+k)*PW +: PW] = tog_tb[i][k][PW-1:0];
    endtask

    function automatic logic lvl(input int i, input int idx);
        logic v = pol[i];
        for (int k = 0; k < NT; k++)
            if (tog_tb[i][k] != ALL1 && tog_tb[i][k] <= idx) v = ~v;
        return v;
    endfunction

    // Runs one region; region and line strobe driven at negedges, checks after each edge.
    task automatic run_case(input string req, input bit sc, input bit mu, input logic [NO-1:0] gb,
                            input int len, input int rep, input int vs, input int line, input int kmax);
        int le, re, n;
        bit me;
        le = (len == 0) ? 1 : len;
        re = (rep == 0) ? 1 : rep;
        n  = le * re;
        me = mu && (gb == '0);
        scan = sc; mult = mu; grpb = gb;
        vlen = len[PW-1:0]; vrep = rep[PW-1:0]; vstart = vs[PW-1:0];
        pack_tog();
        for (int k = 0; k < kmax; k++) begin
            int p;
            int j;
            logic ed;
            hd = (k % line == 0);
            region = 1'b1;
            @(posedge clk);
            @(negedge clk);
            j = k % line;
            p = -1;
            if (sc) p = k - vs - 1;
            else if (j != 0) p = j - vs - 1;
            ed = 1'b0;
            if (p >= 0 && p < n) begin
                for (int i = 0; i < NO; i++)
                    exp_out[i] = lvl(i, me ? (p / le) : (p % le));
                ed = (p == n - 1);
            end
            check(req, vout, exp_out, done, ed);
        end
        hd = 1'b0;
        region = 1'b0;
        for (int g = 0; g < 4; g++) begin
            @(posedge clk);
            @(negedge clk);
            check("R10 hold after region", vout, exp_out, done, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=end");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        int lens [4];
        int reps [3];
        int mlens [3];
        int mreps [3];
        lens = '{1, 3, 5, 8};
        reps = '{1, 2, 3};
        mlens = '{1, 2, 4};
        mreps = '{3, 6, 10};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", vout, 4'b0000, done, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 after release", vout, 4'b0000, done, 1'b0);

        // R2 R3 R4 R9: normal mode sweep, two lines each (burst replays per line)
        seed = 0;
        foreach (lens[a]) foreach (reps[b]) for (int vs = 0; vs <= 2; vs += 2) begin
            gen_tog(seed, lens[a] + 1);
            run_case("R2 R3 R4 R9 normal sweep", 1'b0, 1'b0, '0, lens[a], reps[b], vs, 40, 80);
            seed++;
        end

        // R5: multiplier sweep in scan mode across short lines
        foreach (mlens[a]) foreach (mreps[b]) begin
            gen_tog(seed, mreps[b] + 1);
            run_case("R5 multiplier sweep", 1'b1, 1'b1, '0, mlens[a], mreps[b], 1,
                     16, 2 + mlens[a]*mreps[b] + 8);
            seed++;
        end

        // R5: toggles 2 and 9 with factor 4 switch at pixels 8 and 36
        gen_tog(seed, 10);
        pol[0] = 1'b0;
        tog_tb[0] = '{2, 9, ALL1, ALL1, ALL1, ALL1};
        run_case("R5 scaled toggles 8 and 36", 1'b1, 1'b1, '0, 4, 10, 0, 16, 50);

        // R6: second-group assignment disables multiplier
        gen_tog(seed + 1, 6);
        run_case("R6 multiplier blocked", 1'b0, 1'b1, 4'b0100, 5, 2, 1, 40, 40);

        // R7: long burst cut by each line strobe
        gen_tog(seed + 2, 5);
        run_case("R7 line truncation", 1'b0, 1'b0, '0, 5, 4, 1, 12, 48);

        // R8: scan mode crosses line strobes
        gen_tog(seed + 3, 5);
        run_case("R8 scan across lines", 1'b1, 1'b0, '0, 5, 4, 1, 12, 40);

        // R8: region end stops scan burst, then a fresh region restarts it
        gen_tog(seed + 4, 5);
        run_case("R8 region end", 1'b1, 1'b0, '0, 5, 4, 1, 12, 10);
        run_case("R8 region restart", 1'b1, 1'b0, '0, 5, 4, 1, 12, 30);

        // R11: zero length and repetition act as one
        gen_tog(seed + 5, 2);
        run_case("R11 zero settings", 1'b0, 1'b0, '0, 0, 0, 3, 20, 40);

        // R12: strobes with region low start nothing
        gen_tog(seed + 6, 3);
        pack_tog();
        vstart = '0; vlen = 13'd2; vrep = 13'd2; scan = 1'b0; mult = 1'b0; grpb = '0;
        for (int k = 0; k < 40; k++) begin
            hd = (k % 10 == 0);
            region = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R12 region inactive", vout, exp_out, done, 1'b0);
        end
        hd = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule